// File: doc/BRIEF.md
# Tamper Event Response Controller

This controller watches five tamper indicators and turns them into sanitizing actions. The indicators are a mismatch flag from the background configuration CRC check, a voltage sample and a temperature sample (each a converter code checked against a programmable window), an activity strobe from the JTAG port monitor, and an external tamper pin. Each source can be enabled on its own, and a 2-bit policy per source selects what it triggers: nothing, a configuration wipe, a key erase, or both.

There are two separate action outputs. The key-erase output destroys the stored decryption key. The configuration-wipe command clears configuration memory, all flip-flop contents and the expanded key storage, but it keeps the root key. This is why the two actions are separate. When both actions are requested, the key erase is always issued first and the wipe follows it. A sticky cause register records which enabled sources have fired since the last reset.

Window readings are filtered against noise. A window source fires only after a set number of consecutive out-of-window samples.

Top module: `tamper_resp_ctrl`

## Requirements
- R1: The register `cause_o` has one sticky bit per source: bit 0 for CRC mismatch, bit 1 for voltage, bit 2 for temperature, bit 3 for JTAG activity and bit 4 for the external pin. A bit is set in the cycle after an enabled event on its source. Once set, it stays set until reset.
- R2: An event on a source whose `src_enable_i` bit is 0 sets no cause bit and causes no action.
- R3: The policy of source k sits in `src_policy_i[2k+1:2k]`. The code 00 records the cause only. The code 01 requests a wipe only. The code 10 requests a key erase only. The code 11 requests both.
- R4: A sample is in range when lo <= code <= hi, with both bounds inclusive. It is out of window when code < lo or code > hi.
- R5: A window source fires on the PERSIST_N-th (default 3) consecutive valid out-of-window sample. A valid in-range sample restarts the count. Cycles without a valid sample do not break the streak. The source does not fire again while the streak continues.
- R6: A key-erase request drives `key_clear_o` high for exactly KEY_HOLD (default 4) consecutive cycles. The high cycles start with the cycle after the triggering edge.
- R7: `cfg_wipe_o` is a single-cycle pulse. When both actions are requested, it comes in the cycle right after `key_clear_o` falls.
- R8: A wipe-only request pulses `cfg_wipe_o` in the cycle after the triggering edge, and `key_clear_o` stays low.
- R9: `key_clear_o` and `cfg_wipe_o` are never high together.
- R10: During and right after reset, both action outputs are low and `cause_o` is zero.
- R11: A request that arrives while an action is running is queued and issued later. A wipe queued during a key erase follows that key erase at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_enable_i | input | 5 | Enable per source |
| src_policy_i | input | 10 | 2-bit action policy per source |
| crc_mismatch_i | input | 1 | Background CRC mismatch flag |
| volt_valid_i | input | 1 | Voltage sample strobe |
| volt_code_i | input | 10 | Voltage converter code |
| volt_lo_i | input | 10 | Voltage window lower bound |
| volt_hi_i | input | 10 | Voltage window upper bound |
| temp_valid_i | input | 1 | Temperature sample strobe |
| temp_code_i | input | 10 | Temperature converter code |
| temp_lo_i | input | 10 | Temperature window lower bound |
| temp_hi_i | input | 10 | Temperature window upper bound |
| jtag_activity_i | input | 1 | JTAG port activity strobe |
| ext_tamper_i | input | 1 | External tamper pin |
| key_clear_o | output | 1 | Key-erase pulse |
| cfg_wipe_o | output | 1 | Configuration-wipe command |
| cause_o | output | 5 | Sticky event cause bits |

## Verification
Some properties are checked on every cycle:
- the two actions never overlap;
- the wipe pulse lasts one cycle;
- the key erase lasts exactly the hold length;
- cause bits never clear outside reset;
- a cause bit is only newly set by an enabled source;
- a window trigger never repeats on the next cycle;
- a valid in-range sample zeroes its streak.

Other behaviour can only be shown by the bench's scenarios: the policy decoding per source, the cycle offsets between the event, the key erase and the wipe, the window bounds, the streak rules across gaps and in-range samples, and the queuing of a wipe that arrives during a key erase.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int NUM_SRC  = 5;
  localparam int SRC_CRC  = 0;
  localparam int SRC_VOLT = 1;
  localparam int SRC_TEMP = 2;
  localparam int SRC_JTAG = 3;
  localparam int SRC_PIN  = 4;

  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_WIPE = 2'b01,
    POL_KEY  = 2'b10,
    POL_BOTH = 2'b11
  } tamper_policy_e;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_KEY  = 2'd1,
    ACT_WIPE = 2'd2
  } act_state_e;

  function automatic logic pol_has_key(tamper_policy_e p);
    return (p == POL_KEY) || (p == POL_BOTH);
  endfunction

  function automatic logic pol_has_wipe(tamper_policy_e p);
    return (p == POL_WIPE) || (p == POL_BOTH);
  endfunction

  // inclusive window: in range when lo <= code <= hi
  function automatic logic code_outside(logic [15:0] code, logic [15:0] lo, logic [15:0] hi);
    return (code < lo) || (code > hi);
  endfunction
endpackage

// File: rtl/tamper_window_mon.sv
module tamper_window_mon
  import tamper_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int PERSIST_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  output logic              trig_o
);
  localparam int CNT_W = $clog2(PERSIST_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PERSIST_N);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERSIST_N - 1);

  logic [CNT_W-1:0] streak_q;
  logic             outside;

  assign outside = code_outside(16'(code_i), 16'(lo_i), 16'(hi_i));
  assign trig_o  = sample_valid_i && outside && (streak_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak_q <= '0;
    end else if (sample_valid_i) begin
      if (!outside)                streak_q <= '0;
      else if (streak_q != CNT_MAX) streak_q <= streak_q + 1'b1;
    end
  end

  p_single_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  p_inrange_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid_i && !outside) |=> (streak_q == '0));
endmodule

// File: rtl/tamper_action_seq.sv
module tamper_action_seq
  import tamper_pkg::*;
#(
  parameter int KEY_HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_req_i,
  input  logic wipe_req_i,
  output logic key_clear_o,
  output logic cfg_wipe_o
);
  localparam int HOLD_W = $clog2(KEY_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(KEY_HOLD - 1);

  act_state_e        state_q, state_n;
  logic [HOLD_W-1:0] hold_q;
  logic              pend_key_q, pend_wipe_q;
  logic              key_any, wipe_any;
  logic              key_start, wipe_start;

  assign key_any  = pend_key_q  | key_req_i;
  assign wipe_any = pend_wipe_q | wipe_req_i;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ACT_IDLE: begin
        if (key_any)       state_n = ACT_KEY;
        else if (wipe_any) state_n = ACT_WIPE;
      end
      ACT_KEY: begin
        if (hold_q == HOLD_LAST) state_n = wipe_any ? ACT_WIPE : ACT_IDLE;
      end
      ACT_WIPE: state_n = ACT_IDLE;
      default:  state_n = ACT_IDLE;
    endcase
  end

  assign key_start  = (state_n == ACT_KEY)  && (state_q != ACT_KEY);
  assign wipe_start = (state_n == ACT_WIPE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ACT_IDLE;
      hold_q      <= '0;
      pend_key_q  <= 1'b0;
      pend_wipe_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      hold_q      <= (state_q == ACT_KEY && !key_start) ? hold_q + 1'b1 : '0;
      pend_key_q  <= key_any  & ~key_start;
      pend_wipe_q <= wipe_any & ~wipe_start;
    end
  end

  assign key_clear_o = (state_q == ACT_KEY);
  assign cfg_wipe_o  = (state_q == ACT_WIPE);

  // independent run-length counter for the hold check
  logic [7:0] chk_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)           chk_run_q <= '0;
    else if (key_clear_o) chk_run_q <= chk_run_q + 1'b1;
    else                  chk_run_q <= '0;
  end

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_clear_o && cfg_wipe_o));

  p_wipe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wipe_o |=> !cfg_wipe_o);

  p_key_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(key_clear_o) |-> (chk_run_q == 8'(KEY_HOLD)));
endmodule

// File: rtl/tamper_resp_ctrl.sv
module tamper_resp_ctrl
  import tamper_pkg::*;
#(
  parameter int CODE_W    = 10,
  parameter int PERSIST_N = 3,
  parameter int KEY_HOLD  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     src_enable_i,
  input  logic [2*NUM_SRC-1:0]   src_policy_i,
  input  logic                   crc_mismatch_i,
  input  logic                   volt_valid_i,
  input  logic [CODE_W-1:0]      volt_code_i,
  input  logic [CODE_W-1:0]      volt_lo_i,
  input  logic [CODE_W-1:0]      volt_hi_i,
  input  logic                   temp_valid_i,
  input  logic [CODE_W-1:0]      temp_code_i,
  input  logic [CODE_W-1:0]      temp_lo_i,
  input  logic [CODE_W-1:0]      temp_hi_i,
  input  logic                   jtag_activity_i,
  input  logic                   ext_tamper_i,
  output logic                   key_clear_o,
  output logic                   cfg_wipe_o,
  output logic [NUM_SRC-1:0]     cause_o
);
  logic [NUM_SRC-1:0] raw_ev, live_ev, key_vec, wipe_vec;
  logic               volt_trig, temp_trig;
  logic [NUM_SRC-1:0] cause_q;

  tamper_window_mon #(.CODE_W(CODE_W), .PERSIST_N(PERSIST_N)) u_volt_mon (
    .clk(clk), .rst_n(rst_n), .sample_valid_i(volt_valid_i), .code_i(volt_code_i),
    .lo_i(volt_lo_i), .hi_i(volt_hi_i), .trig_o(volt_trig));

  tamper_window_mon #(.CODE_W(CODE_W), .PERSIST_N(PERSIST_N)) u_temp_mon (
    .clk(clk), .rst_n(rst_n), .sample_valid_i(temp_valid_i), .code_i(temp_code_i),
    .lo_i(temp_lo_i), .hi_i(temp_hi_i), .trig_o(temp_trig));

  always_comb begin
    raw_ev           = '0;
    raw_ev[SRC_CRC]  = crc_mismatch_i;
    raw_ev[SRC_VOLT] = volt_trig;
    raw_ev[SRC_TEMP] = temp_trig;
    raw_ev[SRC_JTAG] = jtag_activity_i;
    raw_ev[SRC_PIN]  = ext_tamper_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    tamper_policy_e pol;
    assign pol         = tamper_policy_e'(src_policy_i[2*g +: 2]);
    assign live_ev[g]  = raw_ev[g] & src_enable_i[g];
    assign key_vec[g]  = live_ev[g] & pol_has_key(pol);
    assign wipe_vec[g] = live_ev[g] & pol_has_wipe(pol);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_q | live_ev;
  end
  assign cause_o = cause_q;

  tamper_action_seq #(.KEY_HOLD(KEY_HOLD)) u_seq (
    .clk(clk), .rst_n(rst_n), .key_req_i(|key_vec), .wipe_req_i(|wipe_vec),
    .key_clear_o(key_clear_o), .cfg_wipe_o(cfg_wipe_o));

  p_cause_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & $past(cause_q)) == $past(cause_q)));

  p_cause_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cause_q & ~$past(cause_q) & ~$past(src_enable_i)) == '0));
endmodule

// File: tb/test_tamper_resp_ctrl.sv
module test_tamper_resp_ctrl;
  localparam int NS = 5;
  localparam int PN = 3;
  localparam int KH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] en = '0;
  logic [2*NS-1:0] pol = '0;
  logic crc = 0, vv = 0, tv = 0, jt = 0, pin = 0;
  logic [9:0] vcode = 10'd500, tcode = 10'd400;
  logic [9:0] vlo = 10'd100, vhi = 10'd900, tlo = 10'd200, thi = 10'd700;
  logic key_o, wipe_o;
  logic [NS-1:0] cause;

  always #4 clk = ~clk;

  tamper_resp_ctrl #(.CODE_W(10), .PERSIST_N(PN), .KEY_HOLD(KH)) i_tamper_resp_ctrl (
    .clk(clk), .rst_n(rst_n), .src_enable_i(en), .src_policy_i(pol),
    .crc_mismatch_i(crc), .volt_valid_i(vv), .volt_code_i(vcode), .volt_lo_i(vlo),
    .volt_hi_i(vhi), .temp_valid_i(tv), .temp_code_i(tcode), .temp_lo_i(tlo),
    .temp_hi_i(thi), .jtag_activity_i(jt), .ext_tamper_i(pin),
    .key_clear_o(key_o), .cfg_wipe_o(wipe_o), .cause_o(cause));

  int n_chk = 0, n_bad = 0;
  int k_cnt, k_first, w_cnt, w_idx, ovl;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    crc = 0; jt = 0; pin = 0; vv = 0; tv = 0; vcode = 10'd500; tcode = 10'd400;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; quiet();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // drives the source at the current negedge; the event edge is the next posedge
  task automatic fire(int s);
    case (s)
      0: crc = 1;
      3: jt = 1;
      4: pin = 1;
      1: for (int k = 0; k < PN; k++) begin
           vv = 1; vcode = 10'd950;
           if (k < PN - 1) @(negedge clk);
         end
      default: for (int k = 0; k < PN; k++) begin
           tv = 1; tcode = 10'd150;
           if (k < PN - 1) @(negedge clk);
         end
    endcase
  endtask

  task automatic observe(int n);
    k_cnt = 0; k_first = -1; w_cnt = 0; w_idx = -1; ovl = 0;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (key_o) begin k_cnt++; if (k_first < 0) k_first = i; end
      if (wipe_o) begin w_cnt++; if (w_idx < 0) w_idx = i; end
      if (key_o && wipe_o) ovl++;
      if (i == 0) quiet();
    end
  endtask

  // {src[2:0], en, pol[1:0], exp_key, exp_wipe}
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {3'd0, 1'b1, 2'b11, 1'b1, 1'b1},
    {3'd1, 1'b1, 2'b01, 1'b0, 1'b1},
    {3'd2, 1'b1, 2'b10, 1'b1, 1'b0},
    {3'd3, 1'b1, 2'b00, 1'b0, 1'b0},
    {3'd4, 1'b1, 2'b11, 1'b1, 1'b1},
    {3'd4, 1'b0, 2'b11, 1'b0, 1'b0},
    {3'd0, 1'b1, 2'b10, 1'b1, 1'b0},
    {3'd3, 1'b1, 2'b01, 1'b0, 1'b1},
    {3'd1, 1'b1, 2'b11, 1'b1, 1'b1},
    {3'd2, 1'b0, 2'b01, 1'b0, 1'b0}
  };

  initial begin
    #1600000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 key in reset", key_o, 0);
    chk("R10 wipe in reset", wipe_o, 0);
    chk("R10 cause in reset", cause, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 cause after reset", cause, 0);

    for (int v = 0; v < NV; v++) begin
      int s;
      logic e, ek, ew;
      logic [1:0] p;
      s = int'(VEC[v][7:5]); e = VEC[v][4]; p = VEC[v][3:2];
      ek = VEC[v][1]; ew = VEC[v][0];
      do_reset();
      en = '0; en[s] = e;
      pol = '0; pol[2*s +: 2] = p;
      fire(s);
      observe(10);
      chk("R1/R2 cause", int'(cause), e ? (1 << s) : 0);
      chk("R3/R6 key cycles", k_cnt, ek ? KH : 0);
      chk("R6 key first", k_first, ek ? 0 : -1);
      chk("R3/R7 wipe count", w_cnt, ew ? 1 : 0);
      chk("R7/R8 wipe index", w_idx, ew ? (ek ? KH : 0) : -1);
      chk("R9 overlap", ovl, 0);
    end

    // R4 boundaries inclusive: in range at lo and hi
    do_reset();
    en = 5'b00010; pol = '0;
    for (int k = 0; k < PN + 2; k++) begin
      vv = 1; vcode = (k % 2) ? 10'd100 : 10'd900; @(negedge clk);
    end
    quiet(); @(negedge clk);
    chk("R4 bounds in range", int'(cause), 0);
    for (int k = 0; k < PN; k++) begin vv = 1; vcode = 10'd99; @(negedge clk); end
    quiet(); @(negedge clk);
    chk("R4 below lo", int'(cause), 2);
    do_reset();
    for (int k = 0; k < PN; k++) begin vv = 1; vcode = 10'd901; @(negedge clk); end
    quiet(); @(negedge clk);
    chk("R4 above hi", int'(cause), 2);

    // R5 in-range sample restarts streak; gaps do not
    do_reset();
    en = 5'b00100;
    for (int k = 0; k < PN - 1; k++) begin tv = 1; tcode = 10'd750; @(negedge clk); end
    tv = 1; tcode = 10'd400; @(negedge clk);
    for (int k = 0; k < PN - 1; k++) begin tv = 1; tcode = 10'd750; @(negedge clk); end
    quiet(); @(negedge clk);
    chk("R5 streak restarted", int'(cause), 0);
    tv = 1; tcode = 10'd750; @(negedge clk);
    quiet(); @(negedge clk);
    chk("R5 streak completes", int'(cause), 4);
    do_reset();
    for (int k = 0; k < PN - 1; k++) begin tv = 1; tcode = 10'd150; @(negedge clk); end
    quiet(); repeat (3) @(negedge clk);
    tv = 1; tcode = 10'd150; @(negedge clk);
    quiet(); @(negedge clk);
    chk("R5 gap keeps streak", int'(cause), 4);

    // R1 sticky and accumulating
    en = 5'b11111; pol = '0;
    pin = 1; @(negedge clk); quiet();
    repeat (20) @(negedge clk);
    chk("R1 sticky cause", int'(cause), 5'b10100);

    // R11 wipe queued during key erase
    do_reset();
    en = 5'b10001; pol = '0; pol[9:8] = 2'b10; pol[1:0] = 2'b01;
    pin = 1;
    k_cnt = 0; w_idx = -1; ovl = 0;
    @(posedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (key_o) k_cnt++;
      if (wipe_o && w_idx < 0) w_idx = i;
      if (key_o && wipe_o) ovl++;
      if (i == 0) begin pin = 0; crc = 1; end
      if (i == 1) crc = 0;
    end
    chk("R11 key cycles", k_cnt, KH);
    chk("R11 queued wipe index", w_idx, KH);
    chk("R9 overlap queued", ovl, 0);

    // R11 simultaneous key-only and wipe-only sources
    do_reset();
    pin = 1; crc = 1;
    observe(10);
    chk("R11 both sources key", k_cnt, KH);
    chk("R7 wipe after key", w_idx, KH);

    // R10 reset clears cause
    do_reset();
    chk("R10 cause cleared", int'(cause), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule